// File: doc/BRIEF.md
# SPI Serial Memory Read Responder

This block is a synthesizable SPI slave that behaves like a small read-only serial memory. It runs on a fast system clock. It watches an active-low chip select, a serial clock and a serial data input. After chip select falls it collects an 8-bit opcode and then a 24-bit start address, both most significant bit first and sampled on rising serial-clock edges. If the opcode is the read opcode, the block streams bytes from an internal byte array. Bits leave on falling serial-clock edges, and the address advances after every byte. The stream continues for as long as chip select stays low.

The serial data output has its own output-enable. It is raised only while data bits are driven, so the enclosing chip can tri-state a shared pin. Raising chip select at any bit position ends the transaction at once. A synchronous preload port fills the array while the bus is idle. All pin edges are seen through synchronizers, so the system clock must run at least four times faster than the serial clock.

Top module: `spi_rd_responder`

## Requirements
- R1: After a falling chip select, the first 8 rising serial-clock edges capture the opcode, most significant bit first.
- R2: Opcode 0x03 is followed by 24 address bits, most significant bit first. Only the low 8 address bits pick a byte; the upper 16 have no effect.
- R3: In a read, data bits change only on falling serial-clock edges, most significant bit first. The first bit appears on the first falling edge after the last address bit.
- R4: After each 8 data bits the byte address increments by one and the next byte follows with no new opcode, wrapping from 0xFF to 0x00.
- R5: Opcode 0x00 returns no data: output-enable stays low until chip select rises.
- R6: Any opcode other than 0x03 or 0x00 is ignored, with output-enable low, until chip select rises.
- R7: Chip select rising at any bit abandons the transaction. The next falling chip select starts a fresh opcode.
- R8: Output-enable is high from the first data bit until chip select rises, and low at all other times, including after reset.
- R9: A preload write (enable, 8-bit address, 8-bit data) stores its byte on the system clock only while chip select is high; a write issued while chip select is low is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csb | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock, idles low |
| sdi | input | 1 | Serial data into the block |
| sdo | output | 1 | Serial data out of the block |
| sdo_oe | output | 1 | High while sdo carries data |
| pl_we | input | 1 | Preload write enable |
| pl_addr | input | MEM_AW | Preload byte address |
| pl_data | input | 8 | Preload byte value |

## Verification
The bench builds the block with its default parameters: a 256-byte array, two synchronizer stages and opcode 0x03. With these values every byte address and the 0xFF to 0x00 wrap can be reached in a short stream. The bench also uses non-zero upper address bytes to show that they are ignored. The serial clock runs at one twelfth of the system clock, so the synchronizer delay stays well inside each half period. The bench aborts transactions in the middle of an address and in the middle of a data byte, and it tries preload writes with chip select both high and low.

// File: rtl/spi_rd_pkg.sv
package spi_rd_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CMD,
      ST_ADDR,
      ST_SEND,
      ST_HOLD
   } rd_state_e;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
   parameter int          W       = 3,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] pin_i,
   output logic [W-1:0] sync_o,
   output logic [W-1:0] prev_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("spi_pin_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            stage_q[s] <= RST_VAL;
         else if (s == 0)
            stage_q[s] <= pin_i;
         else
            stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_o <= RST_VAL;
      else        prev_o <= stage_q[STAGES-1];
   end

   assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/spi_rd_mem.sv
module spi_rd_mem #(
   parameter int AW = 8,
   parameter int DW = 8,
   localparam int DEPTH = 1 << AW
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   if (AW < 2 || AW > 12) begin : g_bad_aw
      $error("spi_rd_mem: AW out of range");
   end

   logic [DW-1:0] arr [DEPTH];

   always_ff @(posedge clk) begin
      if (we) arr[waddr] <= wdata;
   end

   assign rdata = arr[raddr];
endmodule

// File: rtl/spi_rd_responder.sv
module spi_rd_responder
   import spi_rd_pkg::*;
#(
   parameter int          CMD_W    = 8,
   parameter int          ADDR_W   = 24,
   parameter int          MEM_AW   = 8,
   parameter int          SYNC_STG = 2,
   parameter logic [7:0]  OPC_READ = 8'h03
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              csb,
   input  logic              sck,
   input  logic              sdi,
   output logic              sdo,
   output logic              sdo_oe,
   input  logic              pl_we,
   input  logic [MEM_AW-1:0] pl_addr,
   input  logic [7:0]        pl_data
);
   localparam int BYTE_W = 8;
   localparam int BIT_W  = $clog2(BYTE_W);
   localparam int CNT_W  = $clog2(ADDR_W + 1);

   if (CMD_W != 8) begin : g_bad_cmd
      $error("spi_rd_responder: CMD_W must be 8");
   end
   if (MEM_AW > ADDR_W || MEM_AW < 2) begin : g_bad_addr
      $error("spi_rd_responder: MEM_AW must fit in ADDR_W");
   end

   // pin synchronizers: {csb, sck, sdi}; csb resets high
   logic [2:0] pin_s, pin_d;
   spi_pin_sync #(.W(3), .STAGES(SYNC_STG), .RST_VAL(3'b100)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .pin_i ({csb, sck, sdi}),
      .sync_o(pin_s),
      .prev_o(pin_d)
   );

   logic csb_s, sdi_s, csb_fall, sck_rise, sck_fall;
   assign csb_s    = pin_s[2];
   assign sdi_s    = pin_s[0];
   assign csb_fall = pin_d[2] & ~pin_s[2];
   assign sck_rise = ~pin_d[1] & pin_s[1];
   assign sck_fall = pin_d[1] & ~pin_s[1];

   rd_state_e         state;
   logic [CNT_W-1:0]  cnt;
   logic [CMD_W-2:0]  cmd_sh;
   logic [MEM_AW-2:0] addr_sh;
   logic [MEM_AW-1:0] ptr;
   logic [BIT_W-1:0]  bit_idx;
   logic [7:0]        rd_byte;
   logic [CMD_W-1:0]  cmd_nxt;
   logic [MEM_AW-1:0] addr_nxt;

   assign cmd_nxt  = {cmd_sh, sdi_s};
   assign addr_nxt = {addr_sh, sdi_s};

   spi_rd_mem #(.AW(MEM_AW), .DW(8)) u_mem (
      .clk  (clk),
      .we   (pl_we & csb_s),
      .waddr(pl_addr),
      .wdata(pl_data),
      .raddr(ptr),
      .rdata(rd_byte)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         cnt     <= '0;
         cmd_sh  <= '0;
         addr_sh <= '0;
         ptr     <= '0;
         bit_idx <= '0;
         sdo     <= 1'b0;
         sdo_oe  <= 1'b0;
      end else if (csb_s) begin
         state  <= ST_IDLE;
         sdo_oe <= 1'b0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (csb_fall) begin
                  state <= ST_CMD;
                  cnt   <= '0;
               end
            end
            ST_CMD: begin
               if (sck_rise) begin
                  cmd_sh <= cmd_nxt[CMD_W-2:0];
                  cnt    <= cnt + 1'b1;
                  if (cnt == CNT_W'(CMD_W - 1)) begin
                     cnt   <= '0;
                     state <= (cmd_nxt == OPC_READ) ? ST_ADDR : ST_HOLD;
                  end
               end
            end
            ST_ADDR: begin
               if (sck_rise) begin
                  addr_sh <= addr_nxt[MEM_AW-2:0];
                  cnt     <= cnt + 1'b1;
                  if (cnt == CNT_W'(ADDR_W - 1)) begin
                     ptr     <= addr_nxt;
                     bit_idx <= BIT_W'(BYTE_W - 1);
                     state   <= ST_SEND;
                  end
               end
            end
            ST_SEND: begin
               if (sck_fall) begin
                  sdo    <= rd_byte[bit_idx];
                  sdo_oe <= 1'b1;
                  if (bit_idx == '0) begin
                     bit_idx <= BIT_W'(BYTE_W - 1);
                     ptr     <= ptr + 1'b1;
                  end else begin
                     bit_idx <= bit_idx - 1'b1;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   // R8
   oe_only_send_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sdo_oe |-> (state == ST_SEND));

   // R7
   abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      csb_s |=> (state == ST_IDLE && !sdo_oe));

   // R4
   ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SEND && !csb_s && sck_fall && bit_idx == '0)
         |=> ptr == $past(ptr) + 1'b1);

   // R1
   cmd_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_CMD) |-> (cnt < CNT_W'(CMD_W)));

   // R3
   sdo_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sck_fall |=> $stable(sdo));
endmodule

// File: tb/spi_rd_responder_bench.sv
module spi_rd_responder_bench;
   localparam time CLK_PER = 10ns;
   localparam time HALF    = 6 * CLK_PER;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       csb = 1'b1, sck = 1'b0, sdi = 1'b0;
   logic       sdo, sdo_oe;
   logic       pl_we = 1'b0;
   logic [7:0] pl_addr = '0, pl_data = '0;

   int         n_chk = 0, n_err = 0;
   logic [7:0] model [256];
   logic [7:0] exp_q [$];
   logic [7:0] got_byte;
   string      got_tag;
   event       byte_ev;

   always #(CLK_PER/2) clk = ~clk;

   spi_rd_responder u_spi_rd_responder (
      .clk(clk), .rst_n(rst_n), .csb(csb), .sck(sck), .sdi(sdi),
      .sdo(sdo), .sdo_oe(sdo_oe),
      .pl_we(pl_we), .pl_addr(pl_addr), .pl_data(pl_data)
   );

   function automatic logic [7:0] pat(input int i);
      return 8'((i * 29 + 91) ^ (i >> 3));
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // monitor: pops the expected byte for each captured one
   initial begin
      forever begin
         @(byte_ev);
         if (exp_q.size() == 0)
            chk(1'b0, {got_tag, " unexpected byte"}, got_byte, 0);
         else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            chk(got_byte == e, got_tag, got_byte, e);
         end
      end
   end

   task automatic preload(input logic [7:0] a, input logic [7:0] d);
      pl_addr = a; pl_data = d; pl_we = 1'b1;
      #(CLK_PER);
      pl_we = 1'b0;
   endtask

   task automatic send_bit(input logic b);
      sdi = b;
      #(HALF); sck = 1'b1;
      #(HALF); sck = 1'b0;
   endtask

   task automatic send_bits(input logic [31:0] v, input int n);
      for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
   endtask

   task automatic end_txn();
      #(HALF); csb = 1'b1;
      #(2 * HALF);
   endtask

   // R1 R2 R3 R4: read n bytes, then 'extra' further bits before abort
   task automatic do_read(input logic [23:0] addr, input int n, input int extra, input string tag);
      for (int i = 0; i < n; i++) exp_q.push_back(model[8'(addr[7:0] + i)]);
      csb = 1'b0; #(HALF);
      send_bits(32'h03, 8);
      send_bits({8'h0, addr}, 24);
      for (int b = 0; b < n; b++) begin
         logic [7:0] acc;
         for (int k = 0; k < 8; k++) begin
            #(HALF);
            acc = {acc[6:0], sdo};
            if (b == 0 && k == 0) chk(sdo_oe === 1'b1, "R8 oe high on data", sdo_oe, 1);
            sck = 1'b1; #(HALF); sck = 1'b0;
         end
         got_byte = acc; got_tag = tag;
         ->byte_ev;
      end
      for (int k = 0; k < extra; k++) begin
         #(HALF); sck = 1'b1; #(HALF); sck = 1'b0;
      end
      end_txn();
      chk(sdo_oe === 1'b0, "R8 oe low after csb rise", sdo_oe, 0);
   endtask

   // R5 R6: non-read opcode, clock on, oe must stay low
   task automatic do_other(input logic [7:0] opc, input string tag);
      int bad = 0;
      csb = 1'b0; #(HALF);
      send_bits({24'h0, opc}, 8);
      send_bits(32'hFFFF_FFFF, 24);
      for (int k = 0; k < 16; k++) begin
         #(HALF); if (sdo_oe !== 1'b0) bad++;
         sck = 1'b1; #(HALF); sck = 1'b0;
      end
      chk(bad == 0, tag, bad, 0);
      end_txn();
   endtask

   initial begin
      #(CLK_PER * 3 + CLK_PER/2);
      rst_n = 1'b1;
      #(CLK_PER * 4);
      chk(sdo_oe === 1'b0, "R8 reset oe", sdo_oe, 0);
      chk(sdo === 1'b0, "R8 reset sdo", sdo, 0);

      // R9 preload while idle
      for (int i = 0; i < 256; i++) begin
         model[i] = pat(i);
         preload(8'(i), pat(i));
      end
      #(4 * CLK_PER);

      do_read(24'h00_00_04, 3, 0, "R3 read from 0x04");
      do_read(24'h12_34_FE, 4, 0, "R4 wrap and R2 upper bits ignored");
      do_read(24'hFF_00_80, 2, 0, "R2 high address byte ignored");
      do_other(8'h00, "R5 no-op keeps oe low");
      do_other(8'h0B, "R6 unknown opcode keeps oe low");
      do_other(8'hC3, "R6 second unknown opcode keeps oe low");

      // R7 abort inside the address, then a fresh read
      csb = 1'b0; #(HALF);
      send_bits(32'h03, 8);
      send_bits(32'h2A5, 10);
      end_txn();
      chk(sdo_oe === 1'b0, "R7 oe low after address abort", sdo_oe, 0);
      do_read(24'h00_00_30, 2, 0, "R7 read after address abort");

      // R7 abort in the middle of a data byte
      do_read(24'h00_00_60, 1, 5, "R7 read before mid-byte abort");
      do_read(24'h00_00_61, 1, 0, "R7 fresh opcode after mid-byte abort");

      // R9 preload ignored while csb low
      csb = 1'b0; #(HALF);
      send_bits(32'h00, 8);
      preload(8'h40, ~pat(8'h40));
      end_txn();
      do_read(24'h00_00_40, 1, 0, "R9 write with csb low dropped");

      // R9 preload accepted while csb high
      preload(8'h41, 8'hA5);
      model[8'h41] = 8'hA5;
      #(4 * CLK_PER);
      do_read(24'h00_00_41, 1, 0, "R9 write with csb high stored");

      #(4 * CLK_PER);
      chk(exp_q.size() == 0, "R4 all expected bytes seen", exp_q.size(), 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      #(CLK_PER * 150000);
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule